// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It receives the reference clock and the divided feedback clock as ordinary signals. It samples both with a faster measurement clock `clk`. Each input passes through a two-flop synchronizer and a rising-edge detector. Both paths have identical latency, so the relative timing of the two clocks is preserved. The block works one reference period at a time. It counts measurement-clock cycles from the reference edge that opens the period, and it records the distance to the first feedback edge in that period. When the next reference edge closes the period, the phase gap is the smaller of two distances: from the reference edge forward to the feedback edge, and from the feedback edge forward to the closing reference edge. This covers both a lagging and a leading feedback clock.

A measurement FSM has two states. IDLE waits for the first reference edge after reset or power-down; that edge takes it to MEAS. In MEAS, every reference edge completes one measurement and opens the next, staying in MEAS. A measurement is good when a feedback edge was seen in the period and the gap is strictly smaller than `lock_thresh`. A lock FSM counts good results in a row. In OPEN, a good result that takes the run beyond eight moves it to HELD. In HELD, a bad result moves it back to OPEN at once. Reset or power-down returns both FSMs to IDLE and OPEN.

Top module: `pll_lock_detect`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `lock_o`, `meas_done_o` and `meas_good_o` are all 0.
- R2: The gap is min(d, P-d). Here d is the number of `clk` cycles from the opening reference edge to the first feedback edge of the period, and P is the period length in `clk` cycles. A feedback edge that coincides with the reference edge gives d = 0. Lagging and leading feedback are both judged this way.
- R3: A gap equal to `lock_thresh` counts as bad. Only a gap strictly below `lock_thresh` is good.
- R4: A reference period that contains no feedback rising edge counts as bad.
- R5: `lock_o` rises only after the ninth consecutive good measurement. It goes high on the cycle after that measurement's `meas_done_o` pulse, and never earlier than that cycle.
- R6: A single bad measurement clears the run. If `lock_o` is high, it drops on the cycle after that bad result's `meas_done_o` pulse.
- R7: The run counter saturates, so an arbitrarily long series of good results keeps `lock_o` high.
- R8: While `pwrdn` is high, the measurement in progress is abandoned and the run is cleared. `lock_o` is 0 from the cycle after `pwrdn` rises. After power-down, nine fresh good results are needed before `lock_o` rises again.
- R9: `meas_done_o` is a one-cycle pulse. There is one pulse for each reference period completed in MEAS, issued a fixed latency after the closing reference edge. `meas_good_o` carries that period's outcome during the pulse and is 0 otherwise.
- R10: `lock_o` changes only on the cycle after a `meas_done_o` pulse or a cycle with `pwrdn` high. It never changes inside a measurement.
- R11: With `lock_thresh` = 0, no measurement is ever good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn | input | 1 | Power-down, clears measurement and lock |
| ref_clk | input | 1 | Reference clock, sampled asynchronously |
| fb_clk | input | 1 | Divided feedback clock, sampled asynchronously |
| lock_thresh | input | 8 | Lock criterion in `clk` cycles |
| lock_o | output | 1 | Lock flag |
| meas_done_o | output | 1 | One-cycle pulse per completed measurement |
| meas_good_o | output | 1 | Outcome of the measurement flagged by `meas_done_o` |

## Verification
The assertions take three things for granted about the inputs. Both input clocks are slow compared with `clk`, so successive reference edges are several cycles apart. Each feedback pulse falls before the next one rises. `lock_thresh` does not change near the edge that closes a period. The stimulus builds every reference period cycle by cycle: the reference is high for the first half, and the feedback is a two-cycle pulse placed no later than three cycles before the period ends. `lock_thresh` is changed only at mid-period, well after the previous result has been reported. The feedback pulse is placed either after the reference edge or just before the next one, so both lag and lead are exercised.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;
    typedef enum logic {MS_IDLE, MS_MEAS} meas_state_t;
    typedef enum logic {LK_OPEN, LK_HELD} lock_state_t;
endpackage

// File: rtl/pld_edge_sync.sv
module pld_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[LEN-2:0], async_i};
    end

    assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pld_phase_meas.sv
module pld_phase_meas
    import pll_ld_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwrdn,
    input  logic             ref_rise,
    input  logic             fb_rise,
    input  logic [THR_W-1:0] thresh,
    output logic             done_o,
    output logic             good_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meas_state_t      state, state_n;
    logic [CNT_W-1:0] cnt, fb_dist, gap_late, gap_early, gap;
    logic             fb_seen, done_n, good_n;

    assign gap_late  = fb_dist;
    assign gap_early = cnt - fb_dist;
    assign gap       = (gap_late < gap_early) ? gap_late : gap_early;

    // State register
    always_ff @(posedge clk) begin
        if (rst || pwrdn) state <= MS_IDLE;
        else              state <= state_n;
    end

    // Next state and measurement outcome
    always_comb begin
        state_n = state;
        done_n  = 1'b0;
        good_n  = 1'b0;
        unique case (state)
            MS_IDLE: if (ref_rise) state_n = MS_MEAS;
            MS_MEAS: if (ref_rise) begin
                done_n = 1'b1;
                good_n = fb_seen && (gap < CNT_W'(thresh));
            end
        endcase
    end

    // Outputs and period datapath
    always_ff @(posedge clk) begin
        if (rst || pwrdn) begin
            done_o  <= 1'b0;
            good_o  <= 1'b0;
            cnt     <= '0;
            fb_seen <= 1'b0;
            fb_dist <= '0;
        end else begin
            done_o <= done_n;
            good_o <= good_n;
            if (ref_rise) begin
                cnt     <= CNT_W'(1);
                fb_seen <= fb_rise;
                fb_dist <= '0;
            end else begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                if (fb_rise && !fb_seen) begin
                    fb_seen <= 1'b1;
                    fb_dist <= cnt;
                end
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R9
    good_only_done_chk: assert property (@(posedge clk) disable iff (rst)
        good_o |-> done_o);
    // R11
    zero_thr_chk: assert property (@(posedge clk) disable iff (rst)
        good_o |-> ($past(thresh) != '0));
endmodule

// File: rtl/pld_lock_fsm.sv
module pld_lock_fsm
    import pll_ld_pkg::*;
#(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pwrdn,
    input  logic done_i,
    input  logic good_i,
    output logic lock_o
);
    localparam int RUN_MAX = RUN_LEN + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    lock_state_t      state, state_n;
    logic [RUN_W-1:0] run, run_n;

    // State register
    always_ff @(posedge clk) begin
        if (rst || pwrdn) begin
            state <= LK_OPEN;
            run   <= '0;
        end else begin
            state <= state_n;
            run   <= run_n;
        end
    end

    // Next state
    always_comb begin
        run_n   = run;
        state_n = state;
        if (done_i) begin
            if (!good_i)                  run_n = '0;
            else if (int'(run) < RUN_MAX) run_n = run + 1'b1;
        end
        unique case (state)
            LK_OPEN: if (done_i && good_i && int'(run_n) > RUN_LEN) state_n = LK_HELD;
            LK_HELD: if (done_i && !good_i) state_n = LK_OPEN;
        endcase
    end

    // Output
    always_comb lock_o = (state == LK_HELD);

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> $past(done_i && good_i));
    // R6
    bad_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && !good_i) |=> !lock_o);
    // R8
    pwrdn_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pwrdn |=> !lock_o);
    // R10
    lock_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(done_i) && !$past(pwrdn)) |-> $stable(lock_o));
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
    parameter int THR_W   = 8,
    parameter int CNT_W   = 12,
    parameter int RUN_LEN = 8,
    parameter int SYNC_N  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwrdn,
    input  logic             ref_clk,
    input  logic             fb_clk,
    input  logic [THR_W-1:0] lock_thresh,
    output logic             lock_o,
    output logic             meas_done_o,
    output logic             meas_good_o
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in, rise;

    assign raw_in = {fb_clk, ref_clk};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        pld_edge_sync #(.STAGES(SYNC_N)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .async_i(raw_in[g]),
            .rise_o (rise[g])
        );
    end

    pld_phase_meas #(.CNT_W(CNT_W), .THR_W(THR_W)) u_meas (
        .clk     (clk),
        .rst     (rst),
        .pwrdn   (pwrdn),
        .ref_rise(rise[0]),
        .fb_rise (rise[1]),
        .thresh  (lock_thresh),
        .done_o  (meas_done_o),
        .good_o  (meas_good_o)
    );

    pld_lock_fsm #(.RUN_LEN(RUN_LEN)) u_lock (
        .clk   (clk),
        .rst   (rst),
        .pwrdn (pwrdn),
        .done_i(meas_done_o),
        .good_i(meas_good_o),
        .lock_o(lock_o)
    );
endmodule

// File: tb/tb_pll_lock_detect.sv
module tb_pll_lock_detect;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwrdn = 1'b0;
    logic       ref_clk = 1'b0;
    logic       fb_clk = 1'b0;
    logic [7:0] lock_thresh = 8'd4;
    logic       lock_o, meas_done_o, meas_good_o;

    int total = 0;
    int bad = 0;
    int run = 0;
    int pushed = 0;
    int popped = 0;

    bit    q_good[$];
    bit    q_lock[$];
    string q_tag[$];

    always #10 clk = ~clk;

    pll_lock_detect dut (
        .clk(clk), .rst(rst), .pwrdn(pwrdn), .ref_clk(ref_clk), .fb_clk(fb_clk),
        .lock_thresh(lock_thresh), .lock_o(lock_o),
        .meas_done_o(meas_done_o), .meas_good_o(meas_good_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one reference period of p cycles; off < 0 means no feedback edge
    task automatic drive_period(input int p, input int off, input int thr,
                                input bit push, input string tag);
        int  gap;
        bit  good;
        for (int c = 0; c < p; c++) begin
            @(negedge clk);
            ref_clk = (c < p / 2);
            fb_clk  = (off >= 0) && (c == off || c == off + 1);
            if (c == p / 2) lock_thresh = 8'(thr);
        end
        if (push) begin
            gap  = (off < 0) ? 9999 : ((off < p - off) ? off : p - off);
            good = (off >= 0) && (gap < thr);
            run  = good ? ((run < 9) ? run + 1 : 9) : 0;
            q_good.push_back(good);
            q_lock.push_back(run > 8);
            q_tag.push_back(tag);
            pushed++;
        end
    endtask

    task automatic periods(input int n, input int p, input int off, input int thr,
                           input string tag);
        for (int i = 0; i < n; i++) drive_period(p, off, thr, 1'b1, tag);
    endtask

    // Monitor: pops one expected item per completed measurement
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && meas_done_o) begin
                if (q_good.size() == 0) begin
                    check("R9 unexpected meas_done_o", 1, 0);
                end else begin
                    automatic bit    eg = q_good.pop_front();
                    automatic bit    el = q_lock.pop_front();
                    automatic string t  = q_tag.pop_front();
                    popped++;
                    check({t, " meas_good_o"}, meas_good_o, eg);
                    @(negedge clk);
                    check({t, " lock_o"}, lock_o, el);
                    check("R9 done pulse width", meas_done_o, 0);
                end
            end
        end
    end

    initial begin
        #(20ns * 100000);
        check("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 lock_o in reset", lock_o, 0);
        check("R1 meas_done_o in reset", meas_done_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 lock_o after reset", lock_o, 0);
        check("R1 meas_good_o after reset", meas_good_o, 0);

        // R5: eight lagging goods stay unlocked, the ninth locks
        periods(8, 12, 2, 4, "R5 run");
        periods(1, 12, 2, 4, "R5 ninth");
        // R7: long run stays locked
        periods(20, 12, 3, 4, "R7 saturate");
        // R6: single bad result drops lock
        periods(1, 12, 5, 4, "R6 bad");
        // R2: leading feedback (gap 3) and coincident edges (gap 0)
        periods(9, 12, 9, 4, "R2 lead");
        periods(3, 16, 0, 1, "R2 coincident");
        // R3: gap equal to threshold
        periods(2, 12, 4, 4, "R3 equal");
        periods(1, 12, 3, 4, "R3 below");
        // R4: missing feedback edge
        periods(1, 12, -1, 4, "R4 missing");
        // R11: zero threshold rejects gap 0
        periods(2, 12, 0, 0, "R11 zero thr");
        // R8: lock, then power-down
        periods(9, 12, 1, 4, "R8 prelock");
        drive_period(12, 1, 4, 1'b0, "R8 dropped");
        pwrdn = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 lock_o in power-down", lock_o, 0);
        repeat (3) @(negedge clk);
        pwrdn = 1'b0;
        run = 0;
        periods(8, 12, 1, 4, "R8 relock run");
        periods(1, 12, 1, 4, "R8 relock");
        // close the last measurement
        drive_period(12, -1, 4, 1'b0, "R9 tail");
        repeat (10) @(negedge clk);
        check("R9 all results seen", popped, pushed);
        check("R9 queue empty", q_good.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule